// File: doc/BRIEF.md
# Parallel EEPROM Page-Programming Sequencer

This block sits on the host side of a byte-wide parallel EEPROM. A single start request gives a first address and a byte count. The block then takes the bytes one at a time over a valid/ready stream and writes each one with chip-enable and write-enable strobes. Consecutive writes to the same 64-byte page form one burst. The strobe low and high widths are counted in system clocks. While a burst is open, the time between writes is capped: if the stream goes quiet for too long, the burst is closed rather than risk the memory starting its program cycle in the middle of a page.

When a burst closes, the block turns the data bus around and repeats status reads at the last written address until the memory reports that programming has finished. It then continues with the next burst, or signals done. Completion is detected in one of two ways, chosen at build time: two successive reads agree on the toggle bit, or bit 7 of a read matches bit 7 of the last byte written. A watchdog ends the polling with an error if the memory never reports completion.

The data bus is split into an output, an output enable and an input, ready to be joined at a tri-state pad.

Top module: `pgwr_ctrl`

## Requirements
- R1: In reset, and afterwards until a start is taken, mem_ce_n, mem_oe_n and mem_we_n are high, mem_dq_oe is low, and in_ready, busy, done and error are low.
- R2: Every byte write holds mem_ce_n and mem_we_n low with mem_oe_n high for STROBE_LO clocks, and mem_dq_oe stays high until the strobes have risen. The k-th write (counted from 0) targets start_addr+k and carries the k-th accepted stream byte. Exactly byte_count writes are made.
- R3: The page number (address bits 14 down to 6) is the same for every write in a burst. The first burst ends at the first page boundary, and each later burst covers a whole page or the remainder. Without stalls, the number of bursts equals the number of pages touched.
- R4: in_ready is high only while the block waits for a byte, never while any strobe is low. A byte is taken on a clock where in_valid and in_ready are both high.
- R5: If no byte is taken within GAP_WAIT clocks after a write of an open burst, the burst closes and polling starts. The remaining bytes go into a new burst. A shorter stall leaves the burst open.
- R6: mem_dq_oe is low in every cycle with mem_oe_n low, and in the cycle just before mem_oe_n falls.
- R7: Each status read holds mem_ce_n and mem_oe_n low with mem_we_n high for STROBE_LO clocks, at the last written address. Reads repeat until completion is detected. No write or done is issued while the memory is still programming.
- R8: With POLL_MODE = POLL_TOGGLE, a burst completes when two consecutive status reads return the same value on data bit 6.
- R9: With POLL_MODE = POLL_DATA, a burst completes when data bit 7 of a status read equals bit 7 of the last byte written.
- R10: If completion is not seen within POLL_LIMIT clocks of the start of polling, the rest of the transfer is abandoned and done pulses with error high. error stays high until the next start is taken.
- R11: busy is high from the clock after a start is taken until done. done is a single-clock pulse, after which busy is low.
- R12: A start with byte_count 0 pulses done with no strobe activity and no bytes taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_addr | input | ADDR_W | First byte address |
| byte_count | input | CNT_W | Number of bytes to write |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes the byte this clock if valid |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enables the data pad driver |
| mem_dq_in | input | 8 | Data read back from the pad |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| error | output | 1 | Last transfer ended by the polling watchdog |

## Verification
A wrong address counter shows up within one write strobe, as a byte landing one off or a burst crossing into the next page. A page-end decision that is off by one adds a burst or removes one, and this is visible in the burst count as soon as the transfer ends. A completion detector that fires too early allows a write, or done, while the memory model still reports programming. That is caught on the very next strobe. A bus turnaround fault is seen in the single clock where output enable falls.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_WLO,
        S_WHI,
        S_TURN,
        S_RLO,
        S_RHI,
        S_FIN
    } pgwr_state_e;

    typedef enum logic {
        POLL_TOGGLE = 1'b0,
        POLL_DATA   = 1'b1
    } pgwr_poll_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pgwr_pins_t;

    // Pin levels are a pure function of the sequencer state.
    function automatic pgwr_pins_t pins_for(pgwr_state_e s);
        pgwr_pins_t p;
        case (s)
            S_WLO:   p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
            S_WHI:   p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
            S_RLO:   p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
            default: p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        endcase
        return p;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pgwr_tmr.sv
module pgwr_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pgwr_addr.sv
module pgwr_addr #(
    parameter int ADDR_W = 15,
    parameter int CNT_W  = 16,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              step,
    input  logic              dec,
    output logic [ADDR_W-1:0] addr,
    output logic              left_zero,
    output logic              left_one,
    output logic              page_end
);
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            left_q <= load_cnt;
        end else begin
            if (step) addr_q <= addr_q + 1'b1;
            if (dec)  left_q <= left_q - 1'b1;
        end
    end

    assign addr      = addr_q;
    assign left_zero = (left_q == '0);
    assign left_one  = (left_q == CNT_W'(1));
    assign page_end  = &addr_q[PAGE_W-1:0];

    // R2: a write is never counted against an empty transfer
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        dec |-> !left_zero);

endmodule

// File: rtl/pgwr_poll.sv
module pgwr_poll
    import pgwr_pkg::*;
#(
    parameter pgwr_poll_e MODE = POLL_TOGGLE
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic sample,
    input  logic obs_bit,
    input  logic ref_bit,
    output logic complete
);
    generate
        if (MODE == POLL_TOGGLE) begin : g_toggle
            logic have_q;
            logic prev_q;
            logic ref_unused;
            assign ref_unused = ref_bit;
            always_ff @(posedge clk) begin
                if (rst || arm) begin
                    have_q   <= 1'b0;
                    prev_q   <= 1'b0;
                    complete <= 1'b0;
                end else if (sample) begin
                    have_q   <= 1'b1;
                    prev_q   <= obs_bit;
                    complete <= have_q && (prev_q == obs_bit);
                end
            end
        end else begin : g_data
            always_ff @(posedge clk) begin
                if (rst || arm)   complete <= 1'b0;
                else if (sample)  complete <= (obs_bit == ref_bit);
            end
        end
    endgenerate

    // R8 / R9: completion only ever follows a status sample
    p_complete_after_read_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(complete) |-> $past(sample));

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int         ADDR_W     = 15,
    parameter int         PAGE_W     = 6,
    parameter int         CNT_W      = 16,
    parameter int         STROBE_LO  = 2,
    parameter int         STROBE_HI  = 2,
    parameter int         GAP_WAIT   = 16,
    parameter int         POLL_LIMIT = 100000,
    parameter pgwr_poll_e POLL_MODE  = POLL_TOGGLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [7:0]        mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              busy,
    output logic              done,
    output logic              error
);
    localparam int unsigned TMR_MAX = max3(STROBE_LO, STROBE_HI, GAP_WAIT);
    localparam int TMR_W = $clog2(TMR_MAX + 1);
    localparam int WD_W  = $clog2(POLL_LIMIT + 1);

    pgwr_state_e state, nxt;
    pgwr_pins_t  pins;
    logic [7:0]  data_q;
    logic        burst_q, wrote_q, err_q;
    logic        accept, t_zero, wd_zero, complete, in_poll;
    logic        left_zero, left_one, page_end;
    logic        tload, wdload, sample, obs_bit, dq_unused;
    logic [TMR_W-1:0] tval;

    assign accept  = (state == S_WAIT) && in_valid;
    assign in_poll = (state == S_RLO) || (state == S_RHI);
    assign sample  = (state == S_RLO) && t_zero && !wd_zero;
    assign obs_bit = (POLL_MODE == POLL_TOGGLE) ? mem_dq_in[6] : mem_dq_in[7];
    assign dq_unused = ^mem_dq_in;

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE: if (start) nxt = (byte_count == '0) ? S_FIN : S_WAIT;
            S_WAIT: if (in_valid)               nxt = S_WLO;
                    else if (burst_q && t_zero) nxt = S_TURN;
            S_WLO:  if (t_zero) nxt = S_WHI;
            S_WHI:  if (t_zero) nxt = (left_one || page_end) ? S_TURN : S_WAIT;
            S_TURN: nxt = S_RLO;
            S_RLO:  if (wd_zero)     nxt = S_FIN;
                    else if (t_zero) nxt = S_RHI;
            S_RHI:  if (wd_zero)     nxt = S_FIN;
                    else if (t_zero) nxt = !complete ? S_RLO : (left_zero ? S_FIN : S_WAIT);
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        case (nxt)
            S_WLO, S_RLO: tval = TMR_W'(STROBE_LO - 1);
            S_WHI, S_RHI: tval = TMR_W'(STROBE_HI - 1);
            default:      tval = TMR_W'(GAP_WAIT - 1);
        endcase
    end
    assign tload  = (nxt != state);
    assign wdload = (nxt == S_TURN) && (state != S_TURN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            data_q  <= '0;
            burst_q <= 1'b0;
            wrote_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start) begin
                wrote_q <= 1'b0;
                err_q   <= 1'b0;
            end
            if (accept) begin
                data_q  <= in_data;
                burst_q <= 1'b1;
                wrote_q <= 1'b1;
            end
            if (nxt == S_TURN) burst_q <= 1'b0;
            if (in_poll && wd_zero) err_q <= 1'b1;
        end
    end

    pgwr_tmr #(.W(TMR_W)) u_phase (
        .clk(clk), .rst(rst), .load(tload), .val(tval), .zero(t_zero)
    );

    pgwr_tmr #(.W(WD_W)) u_watch (
        .clk(clk), .rst(rst), .load(wdload), .val(WD_W'(POLL_LIMIT - 1)), .zero(wd_zero)
    );

    pgwr_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_addr (
        .clk(clk), .rst(rst),
        .load(state == S_IDLE && start), .load_addr(start_addr), .load_cnt(byte_count),
        .step(accept && wrote_q), .dec(state == S_WHI && t_zero),
        .addr(mem_addr), .left_zero(left_zero), .left_one(left_one), .page_end(page_end)
    );

    pgwr_poll #(.MODE(POLL_MODE)) u_poll (
        .clk(clk), .rst(rst), .arm(state == S_TURN), .sample(sample),
        .obs_bit(obs_bit), .ref_bit(data_q[7]), .complete(complete)
    );

    assign pins       = pins_for(state);
    assign mem_ce_n   = pins.ce_n;
    assign mem_oe_n   = pins.oe_n;
    assign mem_we_n   = pins.we_n;
    assign mem_dq_oe  = pins.dq_oe;
    assign mem_dq_out = data_q;
    assign in_ready   = (state == S_WAIT);
    assign busy       = (state != S_IDLE);
    assign done       = (state == S_FIN);
    assign error      = err_q;

    p_write_strobes_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));
    p_read_strobes_r7: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));
    p_bus_free_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);
    p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));
    p_page_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && burst_q) |-> !page_end);
    p_ready_r4: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (mem_we_n && mem_oe_n));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_err_done_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> done);

endmodule

// File: tb/pgwr_ctrl_tb.sv
`timescale 1ns/1ps
module pgwr_ctrl_tb;
    import pgwr_pkg::*;

    localparam int AW = 15, PW = 6, CW = 16;
    localparam int SLO = 3, SHI = 2, GAP = 20, PLIM = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          sel = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] s_addr = '0;
    logic [CW-1:0] s_cnt = '0;
    logic          vld = 1'b0;
    logic [7:0]    din = '0;
    logic [7:0]    mdl_q;

    logic          t_rdy, t_oe, t_ce, t_oen, t_we, t_busy, t_done, t_err;
    logic [AW-1:0] t_addr;
    logic [7:0]    t_dq;
    logic          d_rdy, d_oe, d_ce, d_oen, d_we, d_busy, d_done, d_err;
    logic [AW-1:0] d_addr;
    logic [7:0]    d_dq;

    pgwr_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .CNT_W(CW), .STROBE_LO(SLO), .STROBE_HI(SHI),
                .GAP_WAIT(GAP), .POLL_LIMIT(PLIM), .POLL_MODE(POLL_TOGGLE)) u_dut (
        .clk(clk), .rst(rst), .start(start && !sel), .start_addr(s_addr), .byte_count(s_cnt),
        .in_valid(vld && !sel), .in_data(din), .in_ready(t_rdy), .mem_addr(t_addr),
        .mem_dq_out(t_dq), .mem_dq_oe(t_oe), .mem_dq_in(mdl_q), .mem_ce_n(t_ce),
        .mem_oe_n(t_oen), .mem_we_n(t_we), .busy(t_busy), .done(t_done), .error(t_err));

    pgwr_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .CNT_W(CW), .STROBE_LO(SLO), .STROBE_HI(SHI),
                .GAP_WAIT(GAP), .POLL_LIMIT(PLIM), .POLL_MODE(POLL_DATA)) u_dut_dp (
        .clk(clk), .rst(rst), .start(start && sel), .start_addr(s_addr), .byte_count(s_cnt),
        .in_valid(vld && sel), .in_data(din), .in_ready(d_rdy), .mem_addr(d_addr),
        .mem_dq_out(d_dq), .mem_dq_oe(d_oe), .mem_dq_in(mdl_q), .mem_ce_n(d_ce),
        .mem_oe_n(d_oen), .mem_we_n(d_we), .busy(d_busy), .done(d_done), .error(d_err));

    logic          m_rdy, m_dqoe, m_ce, m_oe, m_we, m_busy, m_done, m_err;
    logic [AW-1:0] m_addr;
    logic [7:0]    m_dq;
    assign m_rdy  = sel ? d_rdy  : t_rdy;
    assign m_dqoe = sel ? d_oe   : t_oe;
    assign m_ce   = sel ? d_ce   : t_ce;
    assign m_oe   = sel ? d_oen  : t_oen;
    assign m_we   = sel ? d_we   : t_we;
    assign m_busy = sel ? d_busy : t_busy;
    assign m_done = sel ? d_done : t_done;
    assign m_err  = sel ? d_err  : t_err;
    assign m_addr = sel ? d_addr : t_addr;
    assign m_dq   = sel ? d_dq   : t_dq;

    // Memory model: logs writes, programs a burst on the first read after it.
    logic [AW-1:0]    wr_addr [0:511];
    logic [7:0]       wr_data [0:511];
    int               n_wr = 0, n_burst = 0, page_err = 0, early_wr = 0;
    int               rd_addr_err = 0, bus_err = 0, rdy_err = 0, busy_cnt = 0, busy_len = 4;
    logic             in_burst = 1'b0, t6 = 1'b0, pw = 1'b1, po = 1'b1, pdq = 1'b0, mdl_clr = 1'b0;
    logic [7:0]       last_d = '0;
    logic [AW-1:0]    last_a = '0;
    logic [AW-PW-1:0] bpage = '0;

    always @(posedge clk) begin
        if (mdl_clr) begin
            n_wr = 0; n_burst = 0; page_err = 0; early_wr = 0; rd_addr_err = 0;
            bus_err = 0; rdy_err = 0; busy_cnt = 0; in_burst = 1'b0; t6 = 1'b0;
        end else if (!rst) begin
            if (!m_we && pw && !m_ce) begin
                if (busy_cnt > 0) early_wr++;
                if (!in_burst) begin
                    n_burst++;
                    bpage = m_addr[AW-1:PW];
                    in_burst = 1'b1;
                end else if (m_addr[AW-1:PW] != bpage) page_err++;
                if (n_wr < 512) begin
                    wr_addr[n_wr] = m_addr;
                    wr_data[n_wr] = m_dq;
                end
                n_wr++;
                last_d = m_dq;
                last_a = m_addr;
            end
            if (!m_oe && po && !m_ce) begin
                if (m_addr != last_a) rd_addr_err++;
                if (in_burst) begin
                    in_burst = 1'b0;
                    busy_cnt = busy_len;
                end
                if (busy_cnt > 0) begin
                    busy_cnt--;
                    t6 = ~t6;
                end
            end
            if (!m_oe && m_dqoe) bus_err++;
            if (po && !m_oe && pdq) bus_err++;
            if (m_rdy && (!m_we || !m_oe)) rdy_err++;
        end
        pw = m_we; po = m_oe; pdq = m_dqoe;
    end
    assign mdl_q = (busy_cnt != 0) ? {~last_d[7], t6, last_d[5:0]} : last_d;

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((s * 7 + i * 13 + 5) & 255);
    endfunction

    function automatic int pages(input int s, input int n);
        if (n == 0) return 0;
        return ((s + n - 1) >> PW) - (s >> PW) + 1;
    endfunction

    task automatic run(input bit which, input int s, input int n, input int stall_at,
                       input int stall_len, input int extra, input int blen, input bit exp_err);
        int w, mism;
        @(negedge clk);
        mdl_clr = 1'b1; busy_len = blen; sel = which;
        @(negedge clk);
        mdl_clr = 1'b0;
        s_addr = AW'(s); s_cnt = CW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n > 0) chk(m_busy == 1'b1, "R11 busy after start", m_busy, 1);
        for (int i = 0; i < n; i++) begin
            if (i == stall_at) repeat (stall_len) @(negedge clk);
            vld = 1'b1; din = pat(s, i);
            while (!m_rdy) @(negedge clk);
            @(negedge clk);
            vld = 1'b0;
        end
        w = 0;
        while (!m_done && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(m_done == 1'b1, "R11 done reached", m_done, 1);
        chk(exp_err || busy_cnt == 0, which ? "R9 data-poll completion not early" :
            "R8 toggle completion not early", busy_cnt, 0);
        chk(m_err == exp_err, "R10 error flag at done", m_err, exp_err);
        if (!exp_err) begin
            chk(n_wr == n, "R2 write count", n_wr, n);
            mism = 0;
            for (int i = 0; i < n && i < 512; i++)
                if (wr_addr[i] != AW'(s + i) || wr_data[i] != pat(s, i)) mism++;
            chk(mism == 0, "R2 address/data sequence", mism, 0);
            chk(n_burst == pages(s, n) + extra, extra ? "R5 burst count with stall" :
                "R3 burst count", n_burst, pages(s, n) + extra);
            if (n == 0) chk(n_wr == 0 && n_burst == 0, "R12 no activity on zero count", n_wr, 0);
        end
        chk(page_err == 0, "R3 burst within one page", page_err, 0);
        chk(early_wr == 0, "R7 no write while programming", early_wr, 0);
        chk(rd_addr_err == 0, "R7 poll at last written address", rd_addr_err, 0);
        chk(bus_err == 0, "R6 bus released around reads", bus_err, 0);
        chk(rdy_err == 0, "R4 ready only while waiting", rdy_err, 0);
        @(negedge clk);
        chk(!m_done && !m_busy, "R11 done single pulse then idle", m_done, 0);
        if (exp_err) chk(m_err == 1'b1, "R10 error held after done", m_err, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int offs[4];
        int cnts[6];
        offs = '{0, 1, 37, 63};
        cnts = '{1, 2, 63, 64, 65, 130};
        repeat (4) @(negedge clk);
        chk(t_ce && t_oen && t_we && !t_oe && d_ce && d_oen && d_we && !d_oe,
            "R1 strobes idle in reset", 0, 1);
        chk(!t_rdy && !t_busy && !t_done && !t_err && !d_rdy && !d_busy && !d_done && !d_err,
            "R1 flags low in reset", 0, 1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(t_ce && t_oen && t_we && !t_oe && !t_busy, "R1 idle after reset", t_busy, 0);
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 4; a++)
                for (int c = 0; c < 6; c++)
                    run(m[0], offs[a], cnts[c], -1, 0, 0, 4, 1'b0);
        run(1'b0, 5, 40, 10, 40, 1, 4, 1'b0);   // R5 long stall closes burst
        run(1'b0, 5, 40, 10, 5, 0, 4, 1'b0);    // R5 short stall keeps burst
        run(1'b1, 70, 20, 7, 40, 1, 3, 1'b0);   // R5 in data-poll mode
        run(1'b0, 9, 0, -1, 0, 0, 4, 1'b0);     // R12
        run(1'b1, 9, 0, -1, 0, 0, 4, 1'b0);     // R12
        run(1'b0, 100, 1, -1, 0, 0, 100000, 1'b1); // R10 toggle never settles
        run(1'b1, 100, 1, -1, 0, 0, 100000, 1'b1); // R10 data never matches
        run(1'b0, 128, 3, -1, 0, 0, 6, 1'b0);   // error cleared by new start (R10)
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule